// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counters. Each counter is stored as a low byte and a high byte. Each counter has its own run bit, its own clock-source choice and its own choice of four counting modes. A byte-wide register bus reaches six locations: a shared mode register, a control/status register and the four count bytes. Software can write a count byte at any time, including while the counter is running. Every read returns its data one cycle after the address is presented.

A counter is clocked in one of two ways. In interval timing it takes one step per tick of a shared prescaler that divides the system clock. In event counting it takes one step per falling edge on its event pin; that pin is first passed through a synchronizer. Each counter sets its own overflow flag. The flag also drives an interrupt request and stays high until software writes it to zero or the matching acknowledge pulse arrives.

Counter 0 can be split into two independent 8-bit timers. In that case counter 1 is halted and counter 0's high half drives counter 1's flag.

Top module: `dual_timer_unit`

## Requirements
- R1: After synchronous reset, every register reads as 0x00, both run bits are off and both interrupt requests are low.
- R2: Mode code 00 (13-bit) steps only bits 4..0 of the low byte. When those bits wrap from 11111, the high byte is incremented. Bits 7..5 of the low byte keep their written value. The flag is set when the combined 13-bit count wraps to zero.
- R3: Mode code 01 (16-bit) counts {high,low} upward. The wrap from FFFFh to 0000h sets the flag, and counting continues from 0000h.
- R4: Mode code 10 (auto-reload) counts only the low byte. On a step from FFh, the flag is set and the low byte is loaded with the high byte.
- R5: When counter 0 has mode code 11, its low byte and its high byte are separate 8-bit timers. The low half uses counter 0's run bit, gate and source, and its wrap sets flag 0. The high half steps on the internal tick while counter 1's run bit is set, and its wrap sets flag 1. Counter 1 is halted for as long as this mode is selected.
- R6: When counter 1 has mode code 11, it holds its value. It resumes counting once its mode code is changed to any other value.
- R7: Source select 0 steps the counter once every PRESCALE clocks. Source select 1 steps it once per falling edge of its event pin, after a synchronizer of SYNC_STAGES flops; rising edges do not step it.
- R8: With the gate bit set, a counter steps only while its run bit and its gate input are both 1. With the gate bit clear, the run bit alone enables it.
- R9: The bus addresses are 0 for mode, 1 for control, 2 and 3 for the low and high bytes of counter 0, and 4 and 5 for the low and high bytes of counter 1. Mode bits 3..0 (gate, source, mode code) belong to counter 0 and bits 7..4 to counter 1. Control bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0; bits 3..0 are plain storage. Read data appears one cycle after the address.
- R10: A flag is set by hardware. It is cleared by an acknowledge pulse or by writing 0 to its control bit, and writing 1 to that bit sets it. A hardware overflow in the same cycle as a clear leaves the flag set. Each interrupt request output equals its flag.
- R11: A bus write to either count byte of a counter cancels that counter's step in the same cycle. The written byte takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, one cycle after the address |
| evt_pin | input | 2 | Event inputs, one per counter (asynchronous) |
| gate_in | input | 2 | Active-high gate inputs, one per counter (synchronous to clk) |
| irq_ack | input | 2 | Acknowledge pulses that clear the flags |
| irq | output | 2 | Interrupt requests (the overflow flags) |

## Verification
The bench builds the unit with PRESCALE set to 3 and SYNC_STAGES left at 2. Ticks therefore arrive every third clock, so a preloaded counter reaches its wrap, its reload or a split-half overflow within a few dozen cycles. At this ratio an overflow can fall in the same cycle as a held acknowledge or a bus write, so the collision rules are reached as well. A randomized phase mixes mode changes, pin toggling, gating and acknowledges while the reference model follows every cycle.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int BYTE_W   = 8;
  localparam int NARROW_W = 5;
  localparam int ADDR_W   = 3;

  typedef enum logic [1:0] {
    MODE_13    = 2'b00,
    MODE_16    = 2'b01,
    MODE_RLD   = 2'b10,
    MODE_SPLIT = 2'b11
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   evt;
    tmode_e mode;
  } tcfg_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      a_r7_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], pin};
  end

  assign fall = sr[STAGES] & ~sr[STAGES-1];

  a_r7_one_pulse_per_edge: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import dtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  tmode_e            mode,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_a,
  output logic              ovf_b
);
  logic              any_wr;
  logic [BYTE_W-1:0] nlo, nhi;

  assign any_wr = wr_lo | wr_hi;

  always_comb begin
    nlo   = lo;
    nhi   = hi;
    ovf_a = 1'b0;
    ovf_b = 1'b0;
    if (!any_wr) begin
      unique case (mode)
        MODE_13: if (en_a) begin
          if (lo[NARROW_W-1:0] == '1) begin
            nlo[NARROW_W-1:0] = '0;
            nhi   = hi + 1'b1;
            ovf_a = (hi == '1);
          end else begin
            nlo[NARROW_W-1:0] = lo[NARROW_W-1:0] + 1'b1;
          end
        end
        MODE_16: if (en_a) begin
          {nhi, nlo} = {hi, lo} + 1'b1;
          ovf_a      = ({hi, lo} == '1);
        end
        MODE_RLD: if (en_a) begin
          if (lo == '1) begin
            nlo   = hi;
            ovf_a = 1'b1;
          end else begin
            nlo = lo + 1'b1;
          end
        end
        MODE_SPLIT: begin
          if (en_a) begin
            nlo   = lo + 1'b1;
            ovf_a = (lo == '1);
          end
          if (en_b) begin
            nhi   = hi + 1'b1;
            ovf_b = (hi == '1);
          end
        end
        default: ;
      endcase
    end
    if (wr_lo) nlo = wdata;
    if (wr_hi) nhi = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= nlo;
      hi <= nhi;
    end
  end

  a_r2_upper_bits_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_13 && !any_wr) |=> lo[BYTE_W-1:NARROW_W] == $past(lo[BYTE_W-1:NARROW_W]));
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_16 && en_a && !any_wr && lo == '1 && hi == '1) |=> (lo == '0 && hi == '0));
  a_r4_reload_from_high: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RLD && en_a && !any_wr && lo == '1) |=> lo == $past(hi));
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> lo == $past(wdata));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [1:0]        evt_pin,
  input  logic [1:0]        gate_in,
  input  logic [1:0]        irq_ack,
  output logic [1:0]        irq
);
  localparam int NTMR  = 2;
  localparam int CFG_W = $bits(tcfg_t);

  logic [NTMR*CFG_W-1:0] mode_q;
  logic [NTMR-1:0]       tr_q, tf_q;
  logic [3:0]            spare_q;
  logic                  rst_q;

  logic                  tick;
  logic [NTMR-1:0]       fall, en_a, en_b, wr_lo, wr_hi, wr_any, ovf_a, ovf_b, set_f;
  logic [BYTE_W-1:0]     lo_q [NTMR];
  logic [BYTE_W-1:0]     hi_q [NTMR];
  tcfg_t                 cfg  [NTMR];
  logic                  split0, wr_mode, wr_ctl;
  logic [BYTE_W-1:0]     rd_mux;
  logic [NTMR-1:0]       tf_wbit;

  tmr_prescale #(.DIV(PRESCALE)) u_pre (.clk(clk), .rst(rst), .tick(tick));

  assign split0  = (cfg[0].mode == MODE_SPLIT);
  assign wr_mode = bus_we && (bus_addr == A_MODE);
  assign wr_ctl  = bus_we && (bus_addr == A_CTRL);
  assign tf_wbit = {bus_wdata[7], bus_wdata[5]};

  generate
    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_LO0 + 2*i);
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_LO0 + 2*i + 1);
      logic src, allow, halt;

      assign cfg[i]   = mode_q[CFG_W*i +: CFG_W];
      assign wr_lo[i] = bus_we && (bus_addr == LO_A);
      assign wr_hi[i] = bus_we && (bus_addr == HI_A);
      assign wr_any[i] = wr_lo[i] | wr_hi[i];

      tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pin(evt_pin[i]), .fall(fall[i]));

      assign src     = cfg[i].evt ? fall[i] : tick;
      assign allow   = tr_q[i] & (~cfg[i].gate | gate_in[i]);
      assign halt    = (i == 1) ? (split0 | (cfg[1].mode == MODE_SPLIT)) : 1'b0;
      assign en_a[i] = allow & src & ~halt;
      assign en_b[i] = (i == 0) ? (split0 & tr_q[1] & tick) : 1'b0;

      tmr_counter u_cnt (
        .clk(clk), .rst(rst), .mode(cfg[i].mode),
        .en_a(en_a[i]), .en_b(en_b[i]),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
        .lo(lo_q[i]), .hi(hi_q[i]), .ovf_a(ovf_a[i]), .ovf_b(ovf_b[i]));
    end
  endgenerate

  assign set_f[0] = ovf_a[0];
  assign set_f[1] = ovf_a[1] | ovf_b[0];

  always_comb begin
    unique case (bus_addr)
      3'd0:    rd_mux = mode_q;
      3'd1:    rd_mux = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], spare_q};
      3'd2:    rd_mux = lo_q[0];
      3'd3:    rd_mux = hi_q[0];
      3'd4:    rd_mux = lo_q[1];
      3'd5:    rd_mux = hi_q[1];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      mode_q    <= '0;
      tr_q      <= '0;
      tf_q      <= '0;
      spare_q   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_ctl) begin
        tr_q    <= {bus_wdata[6], bus_wdata[4]};
        spare_q <= bus_wdata[3:0];
      end
      for (int i = 0; i < NTMR; i++) begin
        if (set_f[i])        tf_q[i] <= 1'b1;
        else if (irq_ack[i]) tf_q[i] <= 1'b0;
        else if (wr_ctl)     tf_q[i] <= tf_wbit[i];
      end
      bus_rdata <= rd_mux;
    end
  end

  assign irq = tf_q;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (tf_q == '0 && tr_q == '0 && mode_q == '0));
  a_r10_hw_set_wins_0: assert property (@(posedge clk) disable iff (rst)
    set_f[0] |=> tf_q[0]);
  a_r10_hw_set_wins_1: assert property (@(posedge clk) disable iff (rst)
    set_f[1] |=> tf_q[1]);
  a_r6_timer1_halted: assert property (@(posedge clk) disable iff (rst)
    ((split0 || cfg[1].mode == MODE_SPLIT) && !wr_any[1]) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));
  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].gate && !gate_in[0] && cfg[0].mode == MODE_16 && !wr_any[0]) |=> $stable(lo_q[0]));
endmodule

// File: tb/dual_timer_unit_test.sv
module dual_timer_unit_test;
  localparam int PRE = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] pin = '0, gate = '0, ack = '0;
  logic [1:0] irq;
  logic       live = 1'b0;

  always #10 clk = ~clk;

  dual_timer_unit #(.PRESCALE(PRE), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .evt_pin(pin), .gate_in(gate), .irq_ack(ack), .irq(irq));

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string req = "R1";

  // behavioural reference state
  int m_mode, m_spare, m_pc, rd_exp;
  int m_tr [2];
  int m_tf [2];
  int m_lo [2];
  int m_hi [2];
  int hist [2][3];

  function automatic int model_read(int a);
    case (a)
      0: return m_mode;
      1: return m_tf[1]*128 + m_tr[1]*64 + m_tf[0]*32 + m_tr[0]*16 + m_spare;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    live <= !rst;
    if (rst) begin
      m_mode = 0; m_spare = 0; m_pc = 0; rd_exp = 0;
      for (int i = 0; i < 2; i++) begin
        m_tr[i] = 0; m_tf[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
        for (int k = 0; k < 3; k++) hist[i][k] = 0;
      end
    end else begin
      int tick, md[2], setf[2], fl[2], wrote[2], v;
      tick = (m_pc == PRE-1);
      m_pc = tick ? 0 : m_pc + 1;
      rd_exp = model_read(addr);
      for (int i = 0; i < 2; i++) begin
        fl[i] = (hist[i][2] == 1 && hist[i][1] == 0);
        hist[i][2] = hist[i][1]; hist[i][1] = hist[i][0]; hist[i][0] = pin[i];
        md[i] = (m_mode >> (4*i)) & 3;
        setf[i] = 0;
        wrote[i] = we && (addr == 2+2*i || addr == 3+2*i);
      end
      for (int i = 0; i < 2; i++) begin
        int go, g, ev;
        g  = (m_mode >> (4*i+3)) & 1;
        ev = (m_mode >> (4*i+2)) & 1;
        go = m_tr[i] && (!g || gate[i]) && (ev ? fl[i] : tick);
        if (i == 1 && (md[0] == 3 || md[1] == 3)) go = 0;
        if (wrote[i]) go = 0;
        if (go) begin
          case (md[i])
            0: begin
              v = m_hi[i]*32 + (m_lo[i] % 32) + 1;
              if (v == 8192) begin v = 0; setf[i] = 1; end
              m_lo[i] = (m_lo[i] / 32) * 32 + (v % 32);
              m_hi[i] = v / 32;
            end
            1: begin
              v = m_hi[i]*256 + m_lo[i] + 1;
              if (v == 65536) begin v = 0; setf[i] = 1; end
              m_lo[i] = v % 256; m_hi[i] = v / 256;
            end
            2: begin
              if (m_lo[i] == 255) begin m_lo[i] = m_hi[i]; setf[i] = 1; end
              else m_lo[i] = m_lo[i] + 1;
            end
            default: begin
              m_lo[i] = (m_lo[i] + 1) % 256;
              if (m_lo[i] == 0) setf[i] = 1;
            end
          endcase
        end
      end
      if (!wrote[0] && md[0] == 3 && m_tr[1] && tick) begin
        m_hi[0] = (m_hi[0] + 1) % 256;
        if (m_hi[0] == 0) setf[1] = 1;
      end
      if (we) begin
        case (int'(addr))
          0: m_mode = wdata;
          2: m_lo[0] = wdata;
          3: m_hi[0] = wdata;
          4: m_lo[1] = wdata;
          5: m_hi[1] = wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        if (setf[i]) m_tf[i] = 1;
        else if (ack[i]) m_tf[i] = 0;
        else if (we && addr == 1) m_tf[i] = (wdata >> (5 + 2*i)) & 1;
      end
      if (we && addr == 1) begin
        m_tr[0] = (wdata >> 4) & 1;
        m_tr[1] = (wdata >> 6) & 1;
        m_spare = wdata & 15;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (live && !rst) begin
      n_cmp++;
      if (int'(rdata) != rd_exp) begin
        n_bad++;
        $display("FAIL %s read data actual=%02h expected=%02h", req, rdata, rd_exp);
      end
      n_cmp++;
      if (int'(irq) != m_tf[1]*2 + m_tf[0]) begin
        n_bad++;
        $display("FAIL %s irq actual=%0b expected=%0d%0d", req, irq, m_tf[1], m_tf[0]);
      end
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d cycles expected=finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    @(negedge clk); addr = 3'(a);
    @(negedge clk); chk(tag, int'(rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    req = "R1";
    for (int a = 0; a < 6; a++) rd_chk("R1 reset value", a, 0);
    chk("R1 irq after reset", int'(irq), 0);

    req = "R9";
    wr(1, 8'h0A); rd_chk("R9 control spare bits", 1, 8'h0A);
    wr(0, 8'hC6); rd_chk("R9 mode readback", 0, 8'hC6);
    wr(0, 8'h00); wr(5, 8'h77); rd_chk("R9 counter1 high byte", 5, 8'h77);

    req = "R3";
    wr(0, 8'h01); wr(3, 8'hFF); wr(2, 8'hFD); wr(1, 8'h10);
    idle(20);
    chk("R3 flag after FFFF wrap", int'(irq[0]), 1);
    wr(1, 8'h00); rd_chk("R3 high byte continues from zero", 3, 0);

    req = "R2";
    wr(0, 8'h00); wr(3, 8'hFF); wr(2, 8'hFD); wr(1, 8'h10);
    idle(20);
    chk("R2 flag after 13-bit wrap", int'(irq[0]), 1);
    wr(1, 8'h00); @(negedge clk); addr = 3'd2; @(negedge clk);
    chk("R2 low byte upper bits kept", int'(rdata & 8'hE0), 8'hE0);

    req = "R4";
    wr(0, 8'h02); wr(3, 8'hFC); wr(2, 8'hFE); wr(1, 8'h10);
    idle(30);
    chk("R4 flag after reload", int'(irq[0]), 1);
    wr(1, 8'h00); @(negedge clk); addr = 3'd2; @(negedge clk);
    chk("R4 low byte within reload range", int'(rdata >= 8'hFC), 1);

    req = "R5";
    wr(0, 8'h03); wr(3, 8'hFD); wr(2, 8'hFE); wr(4, 8'h10); wr(5, 8'h00); wr(1, 8'h50);
    idle(30);
    chk("R5 both halves raised flags", int'(irq), 3);
    wr(1, 8'h00); rd_chk("R5 counter1 halted during split", 4, 8'h10);

    req = "R6";
    wr(0, 8'h30); wr(4, 8'h20); wr(1, 8'h40);
    idle(20);
    rd_chk("R6 counter1 holds in code 11", 4, 8'h20);
    wr(0, 8'h10); idle(20); @(negedge clk); addr = 3'd4; @(negedge clk);
    chk("R6 counter1 resumes", int'(rdata != 8'h20), 1);
    wr(1, 8'h00);

    req = "R7";
    wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); pin[0] = 1'b1; idle(4);
      @(negedge clk); pin[0] = 1'b0; idle(4);
    end
    idle(4);
    wr(1, 8'h00); rd_chk("R7 one step per falling edge", 2, 3);
    wr(0, 8'h01); wr(2, 8'h00); wr(1, 8'h10); idle(3 * PRE * 4);
    wr(1, 8'h00);

    req = "R8";
    wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00); gate[0] = 1'b0; wr(1, 8'h10);
    idle(12);
    rd_chk("R8 gate low blocks counting", 2, 0);
    @(negedge clk); gate[0] = 1'b1; idle(12);
    wr(1, 8'h00); @(negedge clk); addr = 3'd2; @(negedge clk);
    chk("R8 gate high allows counting", int'(rdata != 0), 1);

    req = "R10";
    wr(1, 8'hA0); @(negedge clk); chk("R10 software sets flags", int'(irq), 3);
    wr(1, 8'h20); @(negedge clk); chk("R10 write zero clears flag1", int'(irq), 1);
    @(negedge clk); ack[0] = 1'b1; @(negedge clk); ack[0] = 1'b0;
    chk("R10 acknowledge clears flag0", int'(irq), 0);
    wr(0, 8'h02); wr(3, 8'hFF); wr(2, 8'hFF); wr(1, 8'h10);
    @(negedge clk); ack[0] = 1'b1; idle(30); ack[0] = 1'b0;
    wr(1, 8'h00);

    req = "R11";
    wr(0, 8'h01); wr(3, 8'h00); wr(1, 8'h10);
    @(negedge clk); we = 1'b1; addr = 3'd2; wdata = 8'h55;
    idle(10);
    chk("R11 write beats increment", int'(rdata), 8'h55);
    @(negedge clk); we = 1'b0;
    wr(1, 8'h00); rd_chk("R11 no carry into high byte", 3, 0);

    req = "R9";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      we    = ($urandom % 6 == 0);
      addr  = 3'($urandom % 8);
      wdata = 8'($urandom);
      if ($urandom % 5 == 0) pin  = 2'($urandom);
      if ($urandom % 9 == 0) gate = 2'($urandom);
      ack = ($urandom % 7 == 0) ? 2'($urandom) : 2'b00;
    end
    @(negedge clk); we = 1'b0; ack = 2'b00;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule